// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a serial line receiver, the host data register and a pair of byte FIFOs (receive and transmit), and decides where every byte goes according to a 2-bit channel mode. Bytes from the line can be stored for the host, echoed straight back out, or both. Host writes to the data register can be sent out or looped back into the receive FIFO. The transmit FIFO drains towards a line serialiser over a valid/ready stream.

The block also holds the channel control register. In that register each path (receive, transmit) has an enable bit and a disable bit, and the disable bit wins. Two self-clearing bits flush the FIFOs. The block tells the line side how much space the current mode leaves, and it pulses an overflow flag whenever a byte is lost to a full FIFO.

Back-pressure rules:
- Transmit drain stream: a byte moves when `tx_valid_o` and `tx_ready_i` are both high. `tx_valid_o` is high exactly while the transmit FIFO holds data.
- Line input: the line cannot be stalled. A byte presented with `line_valid_i` is taken in that cycle. `line_ready_o` and `line_space_o` are flow-control hints, and a byte that finds its FIFO full is dropped and flagged.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control register reads 0x128 (both paths disabled), both FIFOs are empty, `tx_valid_o` is 0 and both overflow flags are 0.
- R2: Line bytes are routed by `mode_i`: 0 (normal) to the receive FIFO; 1 (echo) to both FIFOs; 2 (local loopback) to neither; 3 (remote loopback) to the transmit FIFO.
- R3: A host data write goes to the transmit FIFO in mode 0 and to the receive FIFO in mode 2. In modes 1 and 3 it is dropped.
- R4: A path works only while its enable bit is 1 and its disable bit is 0. The receive path uses control bits 2 (enable) and 3 (disable); the transmit path uses bits 4 and 5. While a path is off, pushes to it are dropped without an overflow flag. While the receive path is off, host reads return 0 and do not pop.
- R5: `line_space_o` is the smallest free space among the FIFOs the current mode routes line bytes into, or DEPTH in mode 2. `line_ready_o` is high exactly when `line_space_o` is nonzero.
- R6: A push into a full FIFO on an enabled path is dropped. The drop raises `rx_ovf_o` or `tx_ovf_o` for one cycle, in the cycle after the push. Fullness is judged on the level at the start of the cycle.
- R7: A host read presents the oldest receive byte on `host_rdata_o` from the cycle after the strobe, in arrival order. A read of an empty receive FIFO returns 0.
- R8: Writing control bit 0 or bit 1 flushes the receive or transmit FIFO in the write cycle. Both bits always read back as 0.
- R9: A line byte flagged with `line_brk_i` is stored as 0x00 whatever `line_data_i` holds.
- R10: A push and a pop on the same FIFO in the same cycle leave its level unchanged.
- R11: The transmit FIFO drains in order whenever `tx_ready_i` is high, whatever the transmit enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode field |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W | Control register write data |
| ctrl_o | output | CTRL_W | Control register readback |
| line_valid_i | input | 1 | Line byte present |
| line_data_i | input | DW | Line byte |
| line_brk_i | input | 1 | Line byte is a break condition |
| line_ready_o | output | 1 | Space available for the line |
| line_space_o | output | CW | Free slots for line bytes in this mode |
| host_wr_i | input | 1 | Host data register write strobe |
| host_wdata_i | input | DW | Host write byte |
| host_rd_i | input | 1 | Host data register read strobe |
| host_rdata_o | output | DW | Byte returned by the last read |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | DW | Transmit head byte |
| tx_ready_i | input | 1 | Serialiser takes the transmit byte |
| rx_level_o | output | CW | Receive FIFO level |
| tx_level_o | output | CW | Transmit FIFO level |
| rx_ovf_o | output | 1 | Receive overflow pulse |
| tx_ovf_o | output | 1 | Transmit overflow pulse |

## Verification
The bench builds the router with DEPTH = 4 and the default 8-bit bytes and 9-bit control register. A depth this small lets every mode fill both FIFOs to full, overflow them and drain them within a few cycles. The bench sweeps all four channel modes against all sixteen combinations of the receive and transmit enable and disable bits. In each combination it runs a traffic pattern that mixes line bytes, breaks, host writes, reads and transmit drains. A queue model predicts levels, read data, overflow pulses and space on every cycle. Directed cases then cover reset, flush, break, the disable override and simultaneous push and pop.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL    = 2'd0,
    CH_ECHO      = 2'd1,
    CH_LOCAL_LB  = 2'd2,
    CH_REMOTE_LB = 2'd3
  } chan_mode_e;

  // control register bit positions
  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_ON    = 2;
  localparam int CB_RX_OFF   = 3;
  localparam int CB_TX_ON    = 4;
  localparam int CB_TX_OFF   = 5;

  typedef struct packed {
    logic line_to_rx;
    logic line_to_tx;
    logic host_to_rx;
    logic host_to_tx;
  } route_t;

  function automatic route_t route_of(chan_mode_e m);
    route_t r;
    r = '0;
    unique case (m)
      CH_NORMAL:    begin r.line_to_rx = 1'b1; r.host_to_tx = 1'b1; end
      CH_ECHO:      begin r.line_to_rx = 1'b1; r.line_to_tx = 1'b1; end
      CH_LOCAL_LB:  begin r.host_to_rx = 1'b1; end
      CH_REMOTE_LB: begin r.line_to_tx = 1'b1; end
      default:      r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uart_chan_fifo.sv
module uart_chan_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_chan_pkg::*;
#(
  parameter int              CTRL_W   = 9,
  parameter logic [CTRL_W-1:0] CTRL_RST = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] clr_mask;

  always_comb begin
    clr_mask = '1;
    clr_mask[CB_RX_FLUSH] = 1'b0;
    clr_mask[CB_TX_FLUSH] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= CTRL_RST & clr_mask;
    else if (wr_i) ctrl_q <= wdata_i & clr_mask;
  end

  assign ctrl_o     = ctrl_q;
  assign rx_en_o    = ctrl_q[CB_RX_ON] && !ctrl_q[CB_RX_OFF];
  assign tx_en_o    = ctrl_q[CB_TX_ON] && !ctrl_q[CB_TX_OFF];
  assign rx_flush_o = wr_i && wdata_i[CB_RX_FLUSH];
  assign tx_flush_o = wr_i && wdata_i[CB_TX_FLUSH];

endmodule

// File: rtl/uart_chan_steer.sv
module uart_chan_steer
  import uart_chan_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    mode_i,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  input  logic          rx_full_i,
  input  logic          tx_full_i,
  input  logic [CW-1:0] rx_free_i,
  input  logic [CW-1:0] tx_free_i,
  input  logic          line_valid_i,
  input  logic [DW-1:0] line_data_i,
  input  logic          line_brk_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_push_o,
  output logic [DW-1:0] tx_data_o,
  output logic          rx_ovf_o,
  output logic          tx_ovf_o,
  output logic [CW-1:0] space_o
);

  route_t        rt;
  logic [DW-1:0] line_byte;
  logic          rx_req, tx_req;

  assign rt        = route_of(chan_mode_e'(mode_i));
  assign line_byte = line_brk_i ? '0 : line_data_i;

  assign rx_req    = (line_valid_i && rt.line_to_rx) || (host_wr_i && rt.host_to_rx);
  assign tx_req    = (line_valid_i && rt.line_to_tx) || (host_wr_i && rt.host_to_tx);
  assign rx_data_o = rt.host_to_rx ? host_wdata_i : line_byte;
  assign tx_data_o = rt.host_to_tx ? host_wdata_i : line_byte;

  assign rx_push_o = rx_req && rx_en_i && !rx_full_i;
  assign tx_push_o = tx_req && tx_en_i && !tx_full_i;
  assign rx_ovf_o  = rx_req && rx_en_i && rx_full_i;
  assign tx_ovf_o  = tx_req && tx_en_i && tx_full_i;

  always_comb begin
    space_o = CW'(DEPTH);
    if (rt.line_to_rx && rx_free_i < space_o) space_o = rx_free_i;
    if (rt.line_to_tx && tx_free_i < space_o) space_o = tx_free_i;
  end

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_chan_pkg::*;
#(
  parameter int                DW       = 8,
  parameter int                DEPTH    = 16,
  parameter int                CTRL_W   = 9,
  parameter logic [CTRL_W-1:0] CTRL_RST = 9'h128,
  localparam int               CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              line_valid_i,
  input  logic [DW-1:0]     line_data_i,
  input  logic              line_brk_i,
  output logic              line_ready_o,
  output logic [CW-1:0]     line_space_o,
  input  logic              host_wr_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic              host_rd_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              tx_ready_i,
  output logic [CW-1:0]     rx_level_o,
  output logic [CW-1:0]     tx_level_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o
);

  logic          rx_en, tx_en, rx_flush, tx_flush;
  logic          rx_push, tx_push, rx_pop, tx_pop;
  logic [DW-1:0] rx_pdata, tx_pdata, rx_head;
  logic          rx_full, tx_full, rx_empty, tx_empty;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_ovf_ev, tx_ovf_ev;
  logic [DW-1:0] rdata_q;
  logic          rx_ovf_q, tx_ovf_q;

  uart_chan_ctrl #(.CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr_i), .wdata_i(ctrl_wdata_i),
    .ctrl_o(ctrl_o), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .rx_flush_o(rx_flush), .tx_flush_o(tx_flush)
  );

  uart_chan_steer #(.DW(DW), .DEPTH(DEPTH)) u_steer (
    .mode_i(mode_i), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_full_i(rx_full), .tx_full_i(tx_full),
    .rx_free_i(CW'(DEPTH) - rx_cnt), .tx_free_i(CW'(DEPTH) - tx_cnt),
    .line_valid_i(line_valid_i), .line_data_i(line_data_i), .line_brk_i(line_brk_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .rx_push_o(rx_push), .rx_data_o(rx_pdata),
    .tx_push_o(tx_push), .tx_data_o(tx_pdata),
    .rx_ovf_o(rx_ovf_ev), .tx_ovf_o(tx_ovf_ev), .space_o(line_space_o)
  );

  uart_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush_i(rx_flush),
    .push_i(rx_push), .push_data_i(rx_pdata), .pop_i(rx_pop),
    .head_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  uart_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush_i(tx_flush),
    .push_i(tx_push), .push_data_i(tx_pdata), .pop_i(tx_pop),
    .head_o(tx_data_o), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign rx_pop = host_rd_i && rx_en && !rx_empty;
  assign tx_pop = tx_ready_i && !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rx_ovf_q <= 1'b0;
      tx_ovf_q <= 1'b0;
    end else begin
      if (host_rd_i) rdata_q <= rx_pop ? rx_head : '0;
      rx_ovf_q <= rx_ovf_ev;
      tx_ovf_q <= tx_ovf_ev;
    end
  end

  assign host_rdata_o = rdata_q;
  assign rx_ovf_o     = rx_ovf_q;
  assign tx_ovf_o     = tx_ovf_q;
  assign tx_valid_o   = !tx_empty;
  assign line_ready_o = (line_space_o != '0);
  assign rx_level_o   = rx_cnt;
  assign tx_level_o   = tx_cnt;

endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int CTRL_W = 9,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              line_valid_i,
  input logic [CW-1:0]     line_space_o,
  input logic              host_rd_i,
  input logic [DW-1:0]     host_rdata_o,
  input logic              tx_valid_o,
  input logic [CW-1:0]     rx_level_o,
  input logic [CW-1:0]     tx_level_o,
  input logic              rx_ovf_o
);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[0]) |=> (rx_level_o == '0));

  assert_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |-> (line_space_o == CW'(DEPTH) - rx_level_o));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_o <= CW'(DEPTH)) && (tx_level_o <= CW'(DEPTH)));

  assert_ovf_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_o |-> ($past(rx_level_o) == CW'(DEPTH)));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && rx_level_o == '0 && !ctrl_wr_i) |=> (host_rdata_o == '0));

  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && line_valid_i && mode_i == 2'd0 && ctrl_o[2] && !ctrl_o[3] &&
     rx_level_o != '0 && rx_level_o != CW'(DEPTH) && !ctrl_wr_i) |=> $stable(rx_level_o));

  assert_tx_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o == (tx_level_o != '0));

endmodule

bind uart_chan_router uart_chan_router_chk #(.DW(DW), .DEPTH(DEPTH), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ctrl_wr_i(ctrl_wr_i),
  .ctrl_wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_o), .line_valid_i(line_valid_i),
  .line_space_o(line_space_o), .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
  .tx_valid_o(tx_valid_o), .rx_level_o(rx_level_o), .tx_level_o(tx_level_o),
  .rx_ovf_o(rx_ovf_o)
);

// File: tb/sim_uart_chan_router.sv
module sim_uart_chan_router;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ctrl_wr = 1'b0;
  logic [8:0] ctrl_wdata = '0, ctrl_rb;
  logic lv = 1'b0, lb = 1'b0, hw = 1'b0, hr = 1'b0, tr = 1'b0;
  logic [7:0] ld = '0, hd = '0, rdata, txd;
  logic lready, txv, rovf, tovf;
  logic [CW-1:0] space, rlev, tlev;

  int tests = 0, fails = 0;
  logic [8:0] mctrl;
  logic [7:0] rq[$];
  logic [7:0] tq[$];

  always #5 clk = ~clk;

  uart_chan_router #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ctrl_wr_i(ctrl_wr),
    .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_rb), .line_valid_i(lv),
    .line_data_i(ld), .line_brk_i(lb), .line_ready_o(lready),
    .line_space_o(space), .host_wr_i(hw), .host_wdata_i(hd),
    .host_rd_i(hr), .host_rdata_o(rdata), .tx_valid_o(txv),
    .tx_data_o(txd), .tx_ready_i(tr), .rx_level_o(rlev),
    .tx_level_o(tlev), .rx_ovf_o(rovf), .tx_ovf_o(tovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_space();
    int sp = D;
    if (mode == 2'd0 || mode == 2'd1) sp = (D - rq.size() < sp) ? D - rq.size() : sp;
    if (mode == 2'd1 || mode == 2'd3) sp = (D - tq.size() < sp) ? D - tq.size() : sp;
    return sp;
  endfunction

  task automatic check_state(input string lvl_tag);
    chk(rlev == CW'(rq.size()), lvl_tag, "rx level", rlev, rq.size());
    chk(tlev == CW'(tq.size()), lvl_tag, "tx level", tlev, tq.size());
    chk(space == CW'(exp_space()), "R5", "line space", space, exp_space());
    chk(lready == (exp_space() != 0), "R5", "line ready", lready, exp_space() != 0);
    chk(txv == (tq.size() != 0), "R11", "tx valid", txv, tq.size() != 0);
    if (tq.size() != 0) chk(txd == tq[0], "R11", "tx head", txd, tq[0]);
  endtask

  task automatic wctrl(input logic [8:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    if (d[0]) rq.delete();
    if (d[1]) tq.delete();
    mctrl = d & 9'h1FC;
    @(posedge clk); #2;
    ctrl_wr = 1'b0;
    chk(ctrl_rb == mctrl, "R8", "ctrl readback", ctrl_rb, mctrl);
    check_state("R8");
  endtask

  task automatic step(input bit v, input logic [7:0] vd, input bit vb, input bit w,
                      input logic [7:0] wd, input bit r, input bit t, input string tag);
    bit rxen, txen, rxreq, txreq, erov, etov, pop_ok;
    logic [7:0] b, rxd, txdd, erd;
    int rc, tc;
    @(negedge clk);
    lv = v; ld = vd; lb = vb; hw = w; hd = wd; hr = r; tr = t;
    rxen = mctrl[2] && !mctrl[3];
    txen = mctrl[4] && !mctrl[5];
    b = vb ? 8'h00 : vd;
    rxreq = 0; txreq = 0; rxd = '0; txdd = '0;
    if (v && (mode == 2'd0 || mode == 2'd1)) begin rxreq = 1; rxd = b; end
    if (w && mode == 2'd2) begin rxreq = 1; rxd = wd; end
    if (v && (mode == 2'd1 || mode == 2'd3)) begin txreq = 1; txdd = b; end
    if (w && mode == 2'd0) begin txreq = 1; txdd = wd; end
    rc = rq.size(); tc = tq.size();
    erov = rxreq && rxen && rc == D;
    etov = txreq && txen && tc == D;
    pop_ok = r && rxen && rc > 0;
    erd = pop_ok ? rq[0] : 8'h00;
    if (pop_ok) void'(rq.pop_front());
    if (t && tc > 0) void'(tq.pop_front());
    if (rxreq && rxen && rc < D) rq.push_back(rxd);
    if (txreq && txen && tc < D) tq.push_back(txdd);
    @(posedge clk); #2;
    lv = 0; lb = 0; hw = 0; hr = 0; tr = 0;
    chk(rovf == erov, "R6", "rx overflow", rovf, erov);
    chk(tovf == etov, "R6", "tx overflow", tovf, etov);
    if (r) chk(rdata == erd, (erd == 8'h00 && !pop_ok) ? "R7" : tag, "read data", rdata, erd);
    check_state(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mctrl = 9'h128;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rb == 9'h128, "R1", "ctrl reset", ctrl_rb, 9'h128);
    chk(rlev == 0 && tlev == 0, "R1", "levels reset", rlev + tlev, 0);
    chk(!txv && !rovf && !tovf, "R1", "flags reset", txv + rovf + tovf, 0);
    // disabled paths drop line and host bytes (R4)
    step(1, 8'h11, 0, 1, 8'h22, 0, 0, "R4");

    // sweep: every mode x every enable/disable combination (R2, R3, R4, R6)
    for (int m = 0; m < 4; m++) begin
      for (int en = 0; en < 16; en++) begin
        mode = 2'(m);
        wctrl(9'({en[3:0], 2'b11}));
        for (int i = 0; i < 10; i++) begin
          step((i % 4) != 3, 8'(m * 64 + en * 4 + i + 1), i == 5, (i % 2) == 0,
               8'(8'hA0 + i), (i % 3) == 1, i >= 6, (m == 2 || m == 0) ? "R3" : "R2");
        end
      end
    end

    // R9 break stored as zero, R7 order and empty read
    mode = 2'd0;
    wctrl(9'h017);
    step(1, 8'h5A, 1, 0, 0, 0, 0, "R9");
    step(1, 8'h3C, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    // R10 simultaneous line push and host pop
    step(1, 8'h01, 0, 0, 0, 0, 0, "R10");
    step(1, 8'h02, 0, 0, 0, 0, 0, "R10");
    step(1, 8'h03, 0, 0, 0, 1, 0, "R10");
    chk(rlev == 2, "R10", "level kept on push+pop", rlev, 2);
    // R4 disable overrides enable: both bits set on receive
    wctrl(9'h01C);
    step(1, 8'h44, 0, 0, 0, 1, 0, "R4");
    chk(rlev == 2 && rdata == 8'h00, "R4", "rx off read", rdata, 0);
    // R8 flush both paths
    wctrl(9'h017);
    chk(ctrl_rb[1:0] == 2'b00 && rlev == 0, "R8", "flush self-clear", rlev, 0);
    // R11 drain continues with tx disabled
    step(0, 0, 0, 1, 8'h77, 0, 0, "R3");
    wctrl(9'h024);
    step(0, 0, 0, 0, 0, 0, 1, "R11");
    chk(tlev == 0, "R11", "drain while off", tlev, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule